// File: doc/BRIEF.md
# USB On-The-Go B-Device Role Sequencer

This block is the control state machine for the B side of a dual-role USB port. It decides when the port acts as a peripheral, when it asks the A-device for a session, when it waits for the A-device to reconnect after a host-role handover, and when it runs as host. The controller sees single-cycle event strobes and a few level inputs from the surrounding port logic. It drives the D+ pull-up enable, the host-mode enable, its current state and a session-request timeout pulse.

Two time windows are measured in clock cycles. The number of cycles comes from the `CLK_HZ` parameter. The session-request window is 100 ms. The wait for the A-device to connect after a handover is 3.125 ms. If the connect wait expires, the port returns to peripheral. A cable change or a loss of session validity sends the controller back to idle from any state, and these two events win over any other event that arrives in the same cycle.

State codes seen on `fsm_state`: 0 idle, 1 session request, 2 peripheral, 3 waiting for connect, 4 host.

Top module: `otg_bdev_fsm`

## Requirements
- R1: After reset, `fsm_state` is 0 (idle), and `dp_pullup_en`, `host_mode` and `srp_timeout` are all low.
- R2: In idle, when `sess_valid` and `id_high` are both high, the controller enters peripheral (code 2). Otherwise, when `app_bus_req` is high and `sess_valid` is low, it enters session request (code 1).
- R3: In session request, `id_toggle` or `srp_ok` returns the controller to idle.
- R4: If session request lasts 100 ms (CLK_HZ/10 cycles) with no exit event, the controller returns to idle and `srp_timeout` is high for exactly one cycle.
- R5: Peripheral moves to wait-for-connect (code 3) only when `hnp_on`, `bus_suspended` and `app_bus_req` are all high. `dp_pullup_en` is low in that state.
- R6: In wait-for-connect, `a_attach` moves the controller to host (code 4) and raises `host_mode`. This takes priority over `bus_resume` and timer expiry in the same cycle.
- R7: In wait-for-connect, `bus_resume` or expiry of the 3.125 ms window (CLK_HZ*3125/1e6 cycles) returns the controller to peripheral with `dp_pullup_en` high.
- R8: `id_toggle` or `sess_drop` sends the controller to idle from every state. These two events override all other events in the same cycle.
- R9: In host, `app_finished` or `a_detach` returns the controller to peripheral: `host_mode` goes low and `dp_pullup_en` goes high.
- R10: The cycle counter restarts on every state entry, so each entry into wait-for-connect gets the full window.
- R11: `dp_pullup_en` is high exactly while the state is peripheral. `host_mode` is high exactly while the state is host. Both change in the same cycle as `fsm_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_toggle | input | 1 | Strobe: ID pin changed |
| sess_drop | input | 1 | Strobe: session validity lost |
| sess_valid | input | 1 | Level: B session valid |
| id_high | input | 1 | Level: ID pin reads high (B-device cable end) |
| srp_ok | input | 1 | Strobe: session request completed |
| hnp_on | input | 1 | Level: role handover enabled by the A-device |
| bus_suspended | input | 1 | Level: bus is suspended |
| app_bus_req | input | 1 | Level: application wants the bus |
| a_attach | input | 1 | Strobe: A-device connect seen |
| bus_resume | input | 1 | Strobe: resume signalling seen |
| a_detach | input | 1 | Strobe: A-device disconnected |
| app_finished | input | 1 | Strobe: application done with the bus |
| dp_pullup_en | output | 1 | D+ pull-up enable |
| host_mode | output | 1 | Host-mode enable |
| fsm_state | output | 3 | Current state code |
| srp_timeout | output | 1 | One-cycle pulse on session-request timeout |

## Verification
The assertions assume that strobes and levels are sampled on the rising edge, and that any combination of events may arrive together. They do not assume that the strobes are mutually exclusive. The one pairing they rely on is that `sess_valid` is low once `sess_drop` has fired, which keeps idle from re-entering peripheral at once. The random stimulus respects this pairing: it clears `sess_valid` whenever it fires `sess_drop`. Strobes fire with low probability and levels change rarely, so every state is held long enough for its exits to be reached. The long timer windows and the same-cycle collisions are covered by directed sequences.

// File: rtl/otg_bdev_fsm.sv
module otg_bdev_fsm #(
  parameter int CLK_HZ  = 48_000_000,
  parameter int SRP_MS  = 100,
  parameter int WAIT_US = 3125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_toggle,
  input  logic       sess_drop,
  input  logic       sess_valid,
  input  logic       id_high,
  input  logic       srp_ok,
  input  logic       hnp_on,
  input  logic       bus_suspended,
  input  logic       app_bus_req,
  input  logic       a_attach,
  input  logic       bus_resume,
  input  logic       a_detach,
  input  logic       app_finished,
  output logic       dp_pullup_en,
  output logic       host_mode,
  output logic [2:0] fsm_state,
  output logic       srp_timeout
);

  localparam longint SRP_L   = (longint'(CLK_HZ) * SRP_MS) / 1000;
  localparam longint WAIT_L  = (longint'(CLK_HZ) * WAIT_US) / 1000000;
  localparam int     SRP_CYC  = (SRP_L < 1) ? 1 : int'(SRP_L);
  localparam int     WAIT_CYC = (WAIT_L < 1) ? 1 : int'(WAIT_L);
  localparam int     MAX_CYC  = (SRP_CYC > WAIT_CYC) ? SRP_CYC : WAIT_CYC;
  localparam int     TW       = $clog2(MAX_CYC + 1);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_SRP  = 3'd1;
  localparam logic [2:0] S_PER  = 3'd2;
  localparam logic [2:0] S_WAIT = 3'd3;
  localparam logic [2:0] S_HOST = 3'd4;

  logic [2:0]    st_q, st_d;
  logic [TW-1:0] cnt_q;
  logic          to_d, to_q, pu_q, he_q;

  wire kill     = id_toggle | sess_drop;
  wire hnp_go   = hnp_on & bus_suspended & app_bus_req;
  wire srp_exp  = (cnt_q == TW'(SRP_CYC - 1));
  wire wait_exp = (cnt_q == TW'(WAIT_CYC - 1));
  wire cnt_sat  = (cnt_q == TW'(MAX_CYC));

  always_comb begin
    st_d = st_q;
    to_d = 1'b0;
    if (kill) begin
      st_d = S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (sess_valid && id_high)          st_d = S_PER;
          else if (app_bus_req && !sess_valid) st_d = S_SRP;
        end
        S_SRP: begin
          if (srp_ok) st_d = S_IDLE;
          else if (srp_exp) begin
            st_d = S_IDLE;
            to_d = 1'b1;
          end
        end
        S_PER:  if (hnp_go) st_d = S_WAIT;
        S_WAIT: begin
          if (a_attach)                   st_d = S_HOST;
          else if (bus_resume || wait_exp) st_d = S_PER;
        end
        S_HOST: if (app_finished || a_detach) st_d = S_PER;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      to_q  <= 1'b0;
      pu_q  <= 1'b0;
      he_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      to_q  <= to_d;
      pu_q  <= (st_d == S_PER);
      he_q  <= (st_d == S_HOST);
      if (st_d != st_q) cnt_q <= '0;
      else if (!cnt_sat) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fsm_state    = st_q;
  assign srp_timeout  = to_q;
  assign dp_pullup_en = pu_q;
  assign host_mode    = he_q;

  // R8
  kill_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_toggle || sess_drop) |=> (fsm_state == S_IDLE));

  // R4
  timeout_from_srp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srp_timeout |-> ($past(fsm_state) == S_SRP && fsm_state == S_IDLE));

  // R5
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == S_PER && !kill && !(hnp_on && bus_suspended && app_bus_req))
      |=> (fsm_state == S_PER));

  // R6
  attach_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == S_WAIT && a_attach && !kill) |=> (fsm_state == S_HOST && host_mode));

  // R9
  host_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == S_HOST && (app_finished || a_detach) && !kill)
      |=> (fsm_state == S_PER && !host_mode && dp_pullup_en));

  // R11
  outputs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_pullup_en == (fsm_state == S_PER)) && (host_mode == (fsm_state == S_HOST)));

endmodule

// File: tb/test_otg_bdev_fsm.sv
`timescale 1ns/1ps
module test_otg_bdev_fsm;
  localparam int HZ   = 64000;
  localparam int SRPN = HZ / 10;
  localparam int WN   = (HZ * 3125) / 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_toggle = 0, sess_drop = 0, sess_valid = 0, id_high = 1, srp_ok = 0;
  logic hnp_on = 0, bus_suspended = 0, app_bus_req = 0, a_attach = 0;
  logic bus_resume = 0, a_detach = 0, app_finished = 0;
  logic dp_pullup_en, host_mode, srp_timeout;
  logic [2:0] fsm_state;

  int errors = 0, checks = 0;
  int m_st = 0, m_cnt = 0;
  bit m_to = 0;

  always #4 clk = ~clk;

  otg_bdev_fsm #(.CLK_HZ(HZ)) i_otg_bdev_fsm (.*);

  function automatic int next_state(int s, int c);
    if (id_toggle || sess_drop) return 0;
    case (s)
      0: if (sess_valid && id_high) return 2;
         else if (app_bus_req && !sess_valid) return 1;
      1: if (srp_ok || c == SRPN - 1) return 0;
      2: if (hnp_on && bus_suspended && app_bus_req) return 3;
      3: if (a_attach) return 4;
         else if (bus_resume || c == WN - 1) return 2;
      4: if (app_finished || a_detach) return 2;
      default: return 0;
    endcase
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    int n;
    @(posedge clk);
    n = next_state(m_st, m_cnt);
    m_to = (m_st == 1 && n == 0 && !id_toggle && !sess_drop && !srp_ok);
    m_cnt = (n != m_st) ? 0 : m_cnt + 1;
    m_st = n;
    @(negedge clk);
    chk({tag, " state"}, int'(fsm_state), m_st);
    chk({tag, " R11 pullup"}, int'(dp_pullup_en), int'(m_st == 2));
    chk({tag, " R11 host"}, int'(host_mode), int'(m_st == 4));
    chk({tag, " timeout"}, int'(srp_timeout), int'(m_to));
    {id_toggle, sess_drop, srp_ok, a_attach, bus_resume, a_detach, app_finished} = '0;
  endtask

  task automatic to_wait(string tag);
    hnp_on = 1; bus_suspended = 1; app_bus_req = 1;
    step(tag);
    hnp_on = 0; bus_suspended = 0; app_bus_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(fsm_state), 0);
    chk("R1 pullup", int'(dp_pullup_en), 0);
    chk("R1 host", int'(host_mode), 0);
    chk("R1 timeout", int'(srp_timeout), 0);
    rst_n = 1;
    // R2 idle to session request, R3 exit by completion
    app_bus_req = 1; step("R2 srp entry"); app_bus_req = 0;
    srp_ok = 1; step("R3 srp done");
    app_bus_req = 1; step("R2 srp entry2"); app_bus_req = 0;
    id_toggle = 1; step("R3 id change");
    // R4 session request timeout
    app_bus_req = 1; step("R4 entry"); app_bus_req = 0;
    for (int k = 0; k < SRPN - 1; k++) step("R4 hold");
    chk("R4 still srp", int'(fsm_state), 1);
    step("R4 expire");
    chk("R4 pulse", int'(srp_timeout), 1);
    step("R4 pulse ends");
    // R2 idle to peripheral
    sess_valid = 1; step("R2 peripheral");
    // R5 partial conditions do not leave peripheral
    hnp_on = 1; bus_suspended = 1; step("R5 no req");
    hnp_on = 0; app_bus_req = 1; step("R5 no hnp"); app_bus_req = 0;
    to_wait("R5 wait entry");
    chk("R5 pullup off", int'(dp_pullup_en), 0);
    // R6 attach beats resume
    a_attach = 1; bus_resume = 1; step("R6 host");
    app_finished = 1; step("R9 done");
    to_wait("R7 wait"); bus_resume = 1; step("R7 resume");
    // R10 timer restarts on entry
    to_wait("R10 wait1");
    for (int k = 0; k < WN / 2; k++) step("R10 part");
    bus_resume = 1; step("R10 resume");
    to_wait("R10 wait2");
    for (int k = 0; k < WN - 1; k++) step("R10 hold");
    chk("R10 full window", int'(fsm_state), 3);
    step("R7 expire");
    chk("R7 back", int'(dp_pullup_en), 1);
    // R8 priority in wait and host
    to_wait("R8 wait"); a_attach = 1; id_toggle = 1; step("R8 beats attach");
    step("R2 re-enter");
    to_wait("R9 wait"); a_attach = 1; step("R9 host");
    a_detach = 1; step("R9 detach");
    to_wait("R8 w2"); a_attach = 1; step("R8 host");
    sess_drop = 1; sess_valid = 0; a_detach = 1; step("R8 sess loss");
    // random phase
    for (int k = 0; k < 20000; k++) begin
      if ($urandom_range(199) == 0) id_toggle = 1;
      if ($urandom_range(149) == 0) begin sess_drop = 1; sess_valid = 0; end
      else if (!sess_valid && $urandom_range(39) == 0) sess_valid = 1;
      if ($urandom_range(299) == 0) id_high = ~id_high;
      if ($urandom_range(49) == 0) srp_ok = 1;
      if ($urandom_range(19) == 0) hnp_on = ~hnp_on;
      if ($urandom_range(9) == 0) bus_suspended = ~bus_suspended;
      if ($urandom_range(7) == 0) app_bus_req = ~app_bus_req;
      if ($urandom_range(29) == 0) a_attach = 1;
      if ($urandom_range(39) == 0) bus_resume = 1;
      if ($urandom_range(59) == 0) a_detach = 1;
      if ($urandom_range(59) == 0) app_finished = 1;
      step("R8 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule